// File: doc/BRIEF.md
# Multi-code PCM line encoder

This block takes an uncoded serial bit stream together with two timing strobes and produces one of ten telemetry line codes on a single output pin. The first strobe marks the start of each bit. The second marks the middle of each bit, which the split-phase and delay-modulation codes need. Along with the coded data it drives a data clock, whose phase can be set to 0 or 180 degrees. It also drives a copy of the uncoded stream that passes through unchanged.

A polarity control can invert the coded output. For avionics flight-data recorders, a second mode turns the clock pin into the complement of the data pin, so that the two pins form a differential data pair. The surrounding chip supplies the strobes from its own bit-rate generator and changes the configuration only while the block is held in reset. Frame assembly and the line drivers belong to neighbouring blocks.

Top module: `pcm_line_encoder`

## Requirements
- R1: While reset is low and on the first cycle after it, the internal code level is 0. `data_out` is therefore 0 when `pol_true`=1 and 1 when `pol_true`=0. `dclk_out` shows the second-half clock level, and `nrz_out` is 0. The randomizer register resets to all zeros, the stored level to 0, and the delay-modulation previous-bit memory to 1.
- R2: `nrz_out` takes the value `nrz_in` had on a `bit_stb` cycle, starting the next cycle. It holds that value until the next `bit_stb`, whatever the code or polarity.
- R3: Code select values are: 0 NRZ-L, 1 NRZ-M, 2 NRZ-S, 3 RZ, 4 bi-phase-L, 5 bi-phase-M, 6 bi-phase-S, 7 DM-M, 8 DM-S, 9 randomized NRZ-L. Under code 0 and under the unused values 10 to 15, both halves of a bit carry the input bit.
- R4: NRZ-M inverts the level for a 1 and keeps it for a 0. NRZ-S inverts it for a 0 and keeps it for a 1. In both codes the level is held for the whole bit.
- R5: RZ gives the bit value in the first half and 0 in the second half.
- R6: Bi-phase-L gives the bit value in the first half and its complement in the second half.
- R7: Bi-phase-M and bi-phase-S always invert the level at the start of a bit. They invert it again at mid-bit for a 1 (M) or for a 0 (S).
- R8: DM-M inverts the level at mid-bit for a 1, and at the start of a bit that is a 0 following a 0. DM-S uses the same rule on the complemented bit.
- R9: Randomized NRZ-L sends b XOR s14 XOR s15 for the whole bit. s14 and s15 are the 14th and 15th most recent transmitted bits. A receiver applying the same XOR to the received bits recovers the input once 15 bits have been received.
- R10: With `pol_true`=0, every coded half-bit level is inverted on `data_out`.
- R11: When not in recorder mode, `dclk_out` is low in the first half of a bit and high in the second half if `clk_phase`=0. It is the reverse if `clk_phase`=1.
- R12: With `arinc_mode`=1, `dclk_out` is always the complement of `data_out`.
- R13: `data_out` changes only in the cycle after a `bit_stb` or `half_stb` cycle. If both strobes arrive in the same cycle, `bit_stb` takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_stb | input | 1 | One-cycle pulse at the start of each bit; captures `nrz_in` |
| half_stb | input | 1 | One-cycle pulse at mid-bit |
| nrz_in | input | 1 | Uncoded input bit, valid with `bit_stb` |
| code_sel | input | 4 | Line code select (values in R3) |
| pol_true | input | 1 | 1 sends levels as coded, 0 inverts them |
| clk_phase | input | 1 | 0 for 0-degree clock, 1 for 180-degree clock |
| arinc_mode | input | 1 | Clock pin carries inverted data |
| data_out | output | 1 | Coded line output |
| dclk_out | output | 1 | Data clock, or inverted data in recorder mode |
| nrz_out | output | 1 | Uncoded copy of the stream |

## Verification
The hardest behaviour to reach is state that builds up across bits. Delay modulation inverts at a bit boundary only when a 0 follows a 0. The randomizer's output depends on bits sent fourteen and fifteen positions earlier. The bench therefore sweeps every code value, both polarities, both clock phases and both clock-pin modes. For each configuration it sends 48 bits from a rotated fixed pattern that contains long runs of 0s and 1s and isolated transitions. For the randomized code, the bench also runs an independent descrambler over the received levels, which shows that the stream synchronizes itself without relying on the bench's own encoder model.

// File: rtl/pcm_lc_pkg.sv
// Package: shared line-code encoding for the PCM line encoder.
// Assumes a 4-bit code select; values above 9 are treated as NRZ-L.
package pcm_lc_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        LC_NRZL  = 4'd0,
        LC_NRZM  = 4'd1,
        LC_NRZS  = 4'd2,
        LC_RZ    = 4'd3,
        LC_BIL   = 4'd4,
        LC_BIM   = 4'd5,
        LC_BIS   = 4'd6,
        LC_DMM   = 4'd7,
        LC_DMS   = 4'd8,
        LC_RNRZL = 4'd9
    } lc_code_e;
endpackage

// File: rtl/pcm_lc_scrambler.sv
// Module: self-synchronizing randomizer for NRZ-L.
// Each output bit is the input bit XOR two taps of a shift register that
// holds previously sent bits. Advances once per bit strobe. Reset clears it.
module pcm_lc_scrambler #(
    parameter int STAGES = 15,
    parameter int TAP_A  = 14,
    parameter int TAP_B  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] hist_q;

    // Combine the input with the two tapped history stages.
    assign dout = din ^ hist_q[TAP_A-1] ^ hist_q[TAP_B-1];

    // Shift the transmitted bit into the history on each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)   hist_q <= '0;
        else if (adv) hist_q <= {hist_q[STAGES-2:0], dout};
    end
endmodule

// File: rtl/pcm_lc_code_core.sv
// Module: computes first-half and second-half levels for the current bit.
// Holds the running line level and the delay-modulation previous bit.
// Assumes bit_stb is a single-cycle pulse once per bit.
module pcm_lc_code_core
    import pcm_lc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic [CODE_W-1:0] code_sel,
    input  logic              din,
    input  logic              scr_bit,
    output logic              lvl_first,
    output logic              lvl_second
);
    logic     lvl_q;
    logic     prev_q;
    logic     dm_bit;
    logic     start_lvl;
    lc_code_e code;

    assign code = lc_code_e'(code_sel);

    // DM-S runs the DM-M rule on the complemented bit.
    assign dm_bit = (code == LC_DMS) ? ~din : din;

    // Level at the start of a delay-modulation bit.
    assign start_lvl = (!dm_bit && !prev_q) ? ~lvl_q : lvl_q;

    // Select both half-bit levels for the chosen code.
    always_comb begin
        lvl_first  = din;
        lvl_second = din;
        unique case (code)
            LC_NRZM: begin
                lvl_first  = din ? ~lvl_q : lvl_q;
                lvl_second = lvl_first;
            end
            LC_NRZS: begin
                lvl_first  = din ? lvl_q : ~lvl_q;
                lvl_second = lvl_first;
            end
            LC_RZ: begin
                lvl_first  = din;
                lvl_second = 1'b0;
            end
            LC_BIL: begin
                lvl_first  = din;
                lvl_second = ~din;
            end
            LC_BIM: begin
                lvl_first  = ~lvl_q;
                lvl_second = din ? lvl_q : ~lvl_q;
            end
            LC_BIS: begin
                lvl_first  = ~lvl_q;
                lvl_second = din ? ~lvl_q : lvl_q;
            end
            LC_DMM, LC_DMS: begin
                lvl_first  = start_lvl;
                lvl_second = dm_bit ? ~start_lvl : start_lvl;
            end
            LC_RNRZL: begin
                lvl_first  = scr_bit;
                lvl_second = scr_bit;
            end
            default: begin
                lvl_first  = din;
                lvl_second = din;
            end
        endcase
    end

    // Remember the level that ends this bit and the DM bit value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            prev_q <= 1'b1;
        end else if (bit_stb) begin
            lvl_q  <= lvl_second;
            prev_q <= dm_bit;
        end
    end
endmodule

// File: rtl/pcm_lc_out_stage.sv
// Module: output registers. Presents the first-half level after bit_stb and
// the second-half level after half_stb; bit_stb wins a collision.
// Applies polarity and builds the data clock or recorder-mode inverse.
module pcm_lc_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic half_stb,
    input  logic raw_bit,
    input  logic lvl_first,
    input  logic lvl_second,
    input  logic pol_true,
    input  logic clk_phase,
    input  logic arinc_mode,
    output logic data_out,
    output logic dclk_out,
    output logic nrz_out
);
    logic lvl_q;
    logic hold_q;
    logic half_q;
    logic nrz_q;

    // Step through the two halves of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            hold_q <= 1'b0;
            half_q <= 1'b1;
            nrz_q  <= 1'b0;
        end else if (bit_stb) begin
            lvl_q  <= lvl_first;
            hold_q <= lvl_second;
            half_q <= 1'b0;
            nrz_q  <= raw_bit;
        end else if (half_stb) begin
            lvl_q  <= hold_q;
            half_q <= 1'b1;
        end
    end

    // Drive coded data, clock pin and uncoded copy.
    always_comb begin
        data_out = lvl_q ^ ~pol_true;
        dclk_out = arinc_mode ? ~data_out : (half_q ^ clk_phase);
        nrz_out  = nrz_q;
    end
endmodule

// File: rtl/pcm_line_encoder.sv
// Module: top of the multi-code PCM line encoder.
// Assumes strobes come from an external bit-rate generator, with bit_stb
// once per bit and half_stb once at mid-bit, and that configuration changes
// only while rst_n is low.
module pcm_line_encoder
    import pcm_lc_pkg::*;
#(
    parameter int SCR_STAGES = 15,
    parameter int SCR_TAP_A  = 14,
    parameter int SCR_TAP_B  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              half_stb,
    input  logic              nrz_in,
    input  logic [CODE_W-1:0] code_sel,
    input  logic              pol_true,
    input  logic              clk_phase,
    input  logic              arinc_mode,
    output logic              data_out,
    output logic              dclk_out,
    output logic              nrz_out
);
    logic scr_bit;
    logic lvl_first;
    logic lvl_second;

    pcm_lc_scrambler #(
        .STAGES (SCR_STAGES),
        .TAP_A  (SCR_TAP_A),
        .TAP_B  (SCR_TAP_B)
    ) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (bit_stb),
        .din   (nrz_in),
        .dout  (scr_bit)
    );

    pcm_lc_code_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .code_sel   (code_sel),
        .din        (nrz_in),
        .scr_bit    (scr_bit),
        .lvl_first  (lvl_first),
        .lvl_second (lvl_second)
    );

    pcm_lc_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .half_stb   (half_stb),
        .raw_bit    (nrz_in),
        .lvl_first  (lvl_first),
        .lvl_second (lvl_second),
        .pol_true   (pol_true),
        .clk_phase  (clk_phase),
        .arinc_mode (arinc_mode),
        .data_out   (data_out),
        .dclk_out   (dclk_out),
        .nrz_out    (nrz_out)
    );
endmodule

// File: rtl/pcm_line_encoder_chk.sv
// Module: assertion checker for the PCM line encoder, bound to the top.
// Assumes configuration is steady outside reset.
module pcm_line_encoder_chk
    import pcm_lc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_stb,
    input logic              half_stb,
    input logic              nrz_in,
    input logic [CODE_W-1:0] code_sel,
    input logic              pol_true,
    input logic              clk_phase,
    input logic              arinc_mode,
    input logic              data_out,
    input logic              dclk_out,
    input logic              nrz_out
);
    logic bit_seen_q;

    // Note whether any bit has started since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       bit_seen_q <= 1'b0;
        else if (bit_stb) bit_seen_q <= 1'b1;
    end

    AST_NRZ_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> (nrz_out == $past(nrz_in)));                          // R2

    AST_RZ_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (code_sel == LC_RZ && half_stb && !bit_stb && pol_true)
            |=> (data_out == 1'b0));                                      // R5

    AST_BIL_MID_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_sel == LC_BIL && half_stb && !bit_stb && bit_seen_q)
            |=> (data_out != $past(data_out)));                           // R6

    AST_CLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (half_stb && !bit_stb && !arinc_mode) |=> (dclk_out == ~clk_phase)); // R11

    AST_CLK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !arinc_mode) |=> (dclk_out == clk_phase));            // R11

    AST_ARINC_INV: assert property (@(posedge clk) disable iff (!rst_n)
        arinc_mode |-> (dclk_out != data_out));                           // R12

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !half_stb)
            |=> (data_out == $past(data_out) || pol_true != $past(pol_true))); // R13
endmodule

bind pcm_line_encoder pcm_line_encoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .half_stb   (half_stb),
    .nrz_in     (nrz_in),
    .code_sel   (code_sel),
    .pol_true   (pol_true),
    .clk_phase  (clk_phase),
    .arinc_mode (arinc_mode),
    .data_out   (data_out),
    .dclk_out   (dclk_out),
    .nrz_out    (nrz_out)
);

// File: tb/pcm_line_encoder_bench.sv
// Bench: sweeps every code value, polarity, clock phase and recorder mode.
// Each configuration receives 48 bits, and every half-bit is compared with
// a model written from the requirements.
module pcm_line_encoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       half_stb = 1'b0;
    logic       nrz_in = 1'b0;
    logic [3:0] code_sel = 4'd0;
    logic       pol_true = 1'b1;
    logic       clk_phase = 1'b0;
    logic       arinc_mode = 1'b0;
    logic       data_out;
    logic       dclk_out;
    logic       nrz_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [47:0] PATTERN = 48'h00F3_5A0C_FF61;

    pcm_line_encoder u_pcm_line_encoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .half_stb   (half_stb),
        .nrz_in     (nrz_in),
        .code_sel   (code_sel),
        .pol_true   (pol_true),
        .clk_phase  (clk_phase),
        .arinc_mode (arinc_mode),
        .data_out   (data_out),
        .dclk_out   (dclk_out),
        .nrz_out    (nrz_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit act, input bit exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s code=%0d pol=%0b ph=%0b ar=%0b actual=%0b expected=%0b",
                     req, what, code_sel, pol_true, clk_phase, arinc_mode, act, exp);
        end
    endtask

    // Compare all three outputs with one expected half-bit level.
    task automatic chk_half(input bit lvl, input bit second, input bit nrz_exp, input string req);
        bit d_exp;
        d_exp = lvl ^ ~pol_true;
        chk(data_out, d_exp, req, "data");
        chk(dclk_out, arinc_mode ? ~d_exp : (second ^ clk_phase),
            arinc_mode ? "R12" : "R11", "dclk");
        chk(nrz_out, nrz_exp, "R2", "nrz");
    endtask

    // Watchdog: an overrun counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int cfg = 0; cfg < 88; cfg++) begin
            bit       m_lvl;
            bit       m_prev;
            bit [14:0] m_scr;
            bit [14:0] rx_hist;
            string    req;
            @(negedge clk);
            rst_n      = 1'b0;
            code_sel   = 4'(cfg / 8);
            pol_true   = cfg[0];
            clk_phase  = cfg[1];
            arinc_mode = cfg[2];
            repeat (2) @(negedge clk);
            // R1: reset state (level 0, clock in second half, copy 0)
            chk_half(1'b0, 1'b1, 1'b0, "R1");
            rst_n = 1'b1;
            @(negedge clk);
            chk_half(1'b0, 1'b1, 1'b0, "R1");
            m_lvl = 1'b0; m_prev = 1'b1; m_scr = '0; rx_hist = '0;
            case (cfg / 8)
                1, 2: req = "R4";
                3: req = "R5";
                4: req = "R6";
                5, 6: req = "R7";
                7, 8: req = "R8";
                9: req = "R9";
                default: req = "R3";
            endcase
            for (int i = 0; i < 48; i++) begin
                bit d, s, e, a, h1, h2;
                d = PATTERN[(i + cfg) % 48];
                s = d ^ m_scr[13] ^ m_scr[14];
                m_scr = {m_scr[13:0], s};
                e = (code_sel == 4'd8) ? ~d : d;
                case (code_sel)
                    4'd1: begin h1 = d ? ~m_lvl : m_lvl; h2 = h1; end
                    4'd2: begin h1 = d ? m_lvl : ~m_lvl; h2 = h1; end
                    4'd3: begin h1 = d; h2 = 1'b0; end
                    4'd4: begin h1 = d; h2 = ~d; end
                    4'd5: begin h1 = ~m_lvl; h2 = d ? m_lvl : ~m_lvl; end
                    4'd6: begin h1 = ~m_lvl; h2 = d ? ~m_lvl : m_lvl; end
                    4'd7, 4'd8: begin
                        a  = (!e && !m_prev) ? ~m_lvl : m_lvl;
                        h1 = a; h2 = e ? ~a : a;
                    end
                    4'd9: begin h1 = s; h2 = s; end
                    default: begin h1 = d; h2 = d; end
                endcase
                m_lvl = h2; m_prev = e;
                nrz_in  = d;
                bit_stb = 1'b1;
                @(negedge clk);
                bit_stb = 1'b0;
                nrz_in  = ~d;
                chk_half(h1, 1'b0, d, req);
                // R10 covered by pol_true=0 configurations in chk_half
                if (code_sel == 4'd9) begin
                    bit rx, rec;
                    rx  = data_out ^ ~pol_true;
                    rec = rx ^ rx_hist[13] ^ rx_hist[14];
                    rx_hist = {rx_hist[13:0], rx};
                    if (i >= 15) chk(rec, d, "R9", "descrambled");
                end
                @(negedge clk);
                chk_half(h1, 1'b0, d, "R13");
                @(negedge clk);
                half_stb = 1'b1;
                @(negedge clk);
                half_stb = 1'b0;
                chk_half(h2, 1'b1, d, req);
                @(negedge clk);
                chk_half(h2, 1'b1, d, "R13");
            end
            // R13: simultaneous strobes, bit_stb wins (NRZ-L only)
            if (code_sel == 4'd0) begin
                nrz_in = 1'b1; bit_stb = 1'b1; half_stb = 1'b1;
                @(negedge clk);
                bit_stb = 1'b0; half_stb = 1'b0;
                chk_half(1'b1, 1'b0, 1'b1, "R13");
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule